// File: doc/BRIEF.md
# Multi-Vector Message-Signalled Interrupt Generator

This block lives inside a device and converts internal interrupt causes into message-signalled interrupt writes. A set of configuration inputs carries what software programmed into the capability registers. These are an enable bit, the number of allocated vectors (as a power of two), a message address split into a low word and an optional upper word with a 64-bit mode flag, and a 16-bit message data value.

Each cause input is a single-cycle event. The event is latched as pending. When the block is enabled and the programmed address is valid, one posted write is issued per pending cause, lowest cause index first. The write carries the programmed address. Its data word is the programmed data with the low bits replaced by the cause index. The number of bits replaced is log2 of the allocated vector count. The write leaves through a valid/ready request port as one 32-bit data beat.

The address is valid when its top 12 bits hold 0xFEE and, in 64-bit mode, the upper word is zero. Bits 19:12 are the destination ID and bits 11:0 are control; both pass through unchanged. While the block is disabled or the address is invalid, causes are held pending and nothing is sent.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset, wr_valid is low and no cause is pending.
- R2: A write is issued only when cfg_addr_lo[31:20] equals 0xFEE and either cfg_addr64 is 0 or cfg_addr_hi is zero. wr_addr[31:0] equals cfg_addr_lo unchanged, so destination ID bits 19:12 pass through.
- R3: wr_data[31:16] is zero. wr_data[15:0] is cfg_data with its low k bits replaced by the low k bits of the cause index. k is cfg_vec_log2 (0 to 5); values 6 and 7 are treated as 5.
- R4: While cfg_enable is 0 or the address check fails, no write starts and causes stay pending. They are sent once both conditions hold.
- R5: When several causes are pending, they are sent one write at a time, lowest index first.
- R6: While wr_valid is high and wr_ready is low, wr_valid stays high and wr_addr and wr_data stay stable, even if the configuration changes.
- R7: A cause that fires again while already pending produces a single write.
- R8: With the block enabled and idle, a cause sampled at clock edge n is presented with wr_valid high after edge n+1. A following pending cause is launched on the edge that accepts the current write.
- R9: When cfg_addr64 is 0, cfg_addr_hi is ignored and wr_addr[63:32] is zero. When cfg_addr64 is 1, wr_addr[63:32] carries cfg_addr_hi, which must be zero for a write to be issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Message interrupts enabled |
| cfg_vec_log2 | input | 3 | log2 of the allocated vector count |
| cfg_addr64 | input | 1 | 64-bit address mode |
| cfg_addr_lo | input | 32 | Message address, low word |
| cfg_addr_hi | input | 32 | Message address, upper word |
| cfg_data | input | 16 | Programmed message data |
| cause_i | input | NUM_CAUSES | One pulse per interrupt event, per cause |
| wr_ready | input | 1 | Write request accepted |
| wr_valid | output | 1 | Write request present |
| wr_addr | output | 64 | Write address |
| wr_data | output | 32 | Write data beat |

## Verification
A pending bit that is lost shows as a write that never appears. A pending bit that sticks shows as a repeated or extra write. Because a reference model of the pending set tracks every launch, either fault is caught at the next write, or at the final drain when all causes should have been sent. A wrong pick in the priority selector shows as a data word whose low bits name a higher index than the lowest pending cause, on the very write concerned. A fault in the output holding register shows as address or data changing during a stall, one cycle after it happens. A gating fault shows as a write that starts on an edge where the sampled configuration was disabled or had a bad address.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;
  localparam logic [11:0] MSI_WINDOW   = 12'hFEE;
  localparam int          VLOG_W       = 3;
  localparam int          MAX_VEC_LOG2 = 5;
  localparam int          MDATA_W      = 16;
  localparam int          BEAT_W       = 32;
  localparam int          ADDR_W       = 64;
endpackage

// File: rtl/msi_pend_arb.sv
module msi_pend_arb #(
  parameter int NUM_CAUSES = 8,
  localparam int IDX_W = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CAUSES-1:0] cause_i,
  input  logic                  take_i,
  output logic                  any_pend_o,
  output logic [IDX_W-1:0]      sel_idx_o
);
  logic [NUM_CAUSES-1:0] pend_q, pend_n, sel_oh;

  always_comb begin
    sel_idx_o = '0;
    for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
      if (pend_q[i]) sel_idx_o = IDX_W'(i);
    end
    sel_oh     = any_pend_o ? (NUM_CAUSES'(1) << sel_idx_o) : '0;
    any_pend_o = |pend_q;
    pend_n     = (pend_q & ~(take_i ? sel_oh : '0)) | cause_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  // R5
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend_o |-> (((sel_oh - NUM_CAUSES'(1)) & pend_q) == '0) && ((sel_oh & pend_q) != '0));

  // R7
  pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_pend_o && !take_i) |=> ($past(pend_q) & ~pend_q) == '0);
endmodule

// File: rtl/msi_msg_fmt.sv
module msi_msg_fmt
  import msi_gen_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [VLOG_W-1:0]  cfg_vec_log2,
  input  logic               cfg_addr64,
  input  logic [31:0]        cfg_addr_lo,
  input  logic [31:0]        cfg_addr_hi,
  input  logic [MDATA_W-1:0] cfg_data,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               addr_ok_o,
  output logic [ADDR_W-1:0]  msg_addr_o,
  output logic [BEAT_W-1:0]  msg_data_o
);
  logic [VLOG_W-1:0]  k;
  logic [MDATA_W-1:0] keep_mask;
  logic [MDATA_W-1:0] idx_ext;

  always_comb begin
    k          = (cfg_vec_log2 > VLOG_W'(MAX_VEC_LOG2)) ? VLOG_W'(MAX_VEC_LOG2) : cfg_vec_log2;
    keep_mask  = (MDATA_W'(1) << k) - MDATA_W'(1);
    idx_ext    = MDATA_W'(idx_i);
    addr_ok_o  = (cfg_addr_lo[31:20] == MSI_WINDOW) && (!cfg_addr64 || (cfg_addr_hi == 32'h0));
    msg_addr_o = {(cfg_addr64 ? cfg_addr_hi : 32'h0), cfg_addr_lo};
    msg_data_o = {{(BEAT_W - MDATA_W){1'b0}}, (cfg_data & ~keep_mask) | (idx_ext & keep_mask)};
  end
endmodule

// File: rtl/msi_wr_port.sv
module msi_wr_port
  import msi_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BEAT_W-1:0] data_i,
  input  logic              ready_i,
  output logic              free_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] data_o
);
  logic              valid_n;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] data_q;

  always_comb begin
    free_o  = !valid_o || ready_i;
    valid_n = load_i ? 1'b1 : (valid_o && !ready_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o && $stable(addr_o) && $stable(data_o));
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
  import msi_gen_pkg::*;
#(
  parameter int NUM_CAUSES = 8,
  localparam int IDX_W = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_enable,
  input  logic [VLOG_W-1:0]     cfg_vec_log2,
  input  logic                  cfg_addr64,
  input  logic [31:0]           cfg_addr_lo,
  input  logic [31:0]           cfg_addr_hi,
  input  logic [MDATA_W-1:0]    cfg_data,
  input  logic [NUM_CAUSES-1:0] cause_i,
  input  logic                  wr_ready,
  output logic                  wr_valid,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [BEAT_W-1:0]     wr_data
);
  logic              any_pend, addr_ok, slot_free, take;
  logic [IDX_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] msg_addr;
  logic [BEAT_W-1:0] msg_data;

  assign take = slot_free && any_pend && cfg_enable && addr_ok;

  msi_pend_arb #(.NUM_CAUSES(NUM_CAUSES)) u_arb (
    .clk(clk), .rst_n(rst_n), .cause_i(cause_i), .take_i(take),
    .any_pend_o(any_pend), .sel_idx_o(sel_idx)
  );

  msi_msg_fmt #(.IDX_W(IDX_W)) u_fmt (
    .cfg_vec_log2(cfg_vec_log2), .cfg_addr64(cfg_addr64),
    .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
    .idx_i(sel_idx), .addr_ok_o(addr_ok), .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  msi_wr_port u_port (
    .clk(clk), .rst_n(rst_n), .load_i(take), .addr_i(msg_addr), .data_i(msg_data),
    .ready_i(wr_ready), .free_o(slot_free), .valid_o(wr_valid),
    .addr_o(wr_addr), .data_o(wr_data)
  );

  // R4
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(cfg_enable));

  // R2
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[31:20] == MSI_WINDOW) && (wr_addr[63:32] == 32'h0));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !wr_valid);
endmodule

// File: tb/msi_msg_gen_tb.sv
module msi_msg_gen_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [2:0]  cfg_vec_log2 = 3'd3;
  logic        cfg_addr64 = 1'b0;
  logic [31:0] cfg_addr_lo = 32'hFEE0_5000;
  logic [31:0] cfg_addr_hi = 32'h0;
  logic [15:0] cfg_data = 16'h0032;
  logic [N-1:0] cause_i = '0;
  logic        wr_ready = 1'b1;
  logic        wr_valid;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0, fails = 0, nwrites = 0;
  logic [31:0] wlog [0:15];

  always #4 clk = ~clk;

  msi_msg_gen #(.NUM_CAUSES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_vec_log2(cfg_vec_log2),
    .cfg_addr64(cfg_addr64), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
    .cfg_data(cfg_data), .cause_i(cause_i), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] exp_data(logic [15:0] d, logic [2:0] k, int idx);
    int kk = (k > 3'd5) ? 5 : int'(k);
    logic [15:0] m = 16'((32'd1 << kk) - 1);
    return {16'h0, (d & ~m) | (16'(idx) & m)};
  endfunction

  function automatic bit addr_good(logic [31:0] lo, logic [31:0] hi, logic m64);
    return (lo[31:20] == 12'hFEE) && (!m64 || hi == 32'h0);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic fire(logic [N-1:0] m);
    tick(); cause_i = m; tick(); cause_i = '0;
  endtask

  // reference model, sampled at falling edges
  logic [N-1:0] mpend = '0, c_prev = '0;
  logic pv = 0, pr = 0, s_en = 0, s_64 = 0;
  logic [2:0] s_k = '0;
  logic [31:0] s_lo = '0, s_hi = '0;
  logic [15:0] s_d = '0;
  logic [63:0] sv_addr = '0;
  logic [31:0] sv_data = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mpend = '0; c_prev = '0; pv = 0; pr = 0;
    end else begin
      if (pv && !pr)  // R6
        chk(wr_valid && wr_addr == sv_addr && wr_data == sv_data, "R6 hold",
            {wr_data, wr_addr[31:0]}, {sv_data, sv_addr[31:0]});
      if (wr_valid && (!pv || pr)) begin
        int lo = 0;
        for (int i = N - 1; i >= 0; i--) if (mpend[i]) lo = i;
        // R2 R3 R4 R5 R9: launched write matches lowest pending under a valid config
        chk(mpend != '0 && s_en && addr_good(s_lo, s_hi, s_64), "R4/R5 launch",
            {32'h0, 24'h0, mpend}, {32'h0, 32'h1});
        chk(wr_data == exp_data(s_d, s_k, lo) && wr_addr == {32'h0, s_lo}, "R2/R3/R5 content",
            {wr_data, wr_addr[31:0]}, {exp_data(s_d, s_k, lo), s_lo});
        mpend[lo] = 1'b0;
        if (nwrites < 16) wlog[nwrites] = wr_data;
        nwrites++;
      end
      mpend = mpend | c_prev;
      c_prev = cause_i;
      s_en = cfg_enable; s_64 = cfg_addr64; s_k = cfg_vec_log2;
      s_lo = cfg_addr_lo; s_hi = cfg_addr_hi; s_d = cfg_data;
      pv = wr_valid; pr = wr_ready; sv_addr = wr_addr; sv_data = wr_data;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    @(negedge clk);
    chk(!wr_valid, "R1 reset", {63'h0, wr_valid}, 64'h0);
    tick(); rst_n = 1'b1; tick();
    @(negedge clk);
    chk(!wr_valid, "R1 idle", {63'h0, wr_valid}, 64'h0);

    // R4 R5 R3: held while disabled, then lowest first
    fire(8'b0010_1000);
    repeat (8) tick();
    @(negedge clk);
    chk(!wr_valid && nwrites == 0, "R4 disabled", {63'h0, wr_valid}, 64'h0);
    tick(); cfg_enable = 1'b1;
    repeat (6) tick();
    chk(nwrites == 2 && wlog[0] == 32'h33 && wlog[1] == 32'h35, "R5 order",
        {wlog[0], wlog[1]}, {32'h33, 32'h35});

    // R2 R4: bad window blocks, fix releases; dest ID 0xA5 passes
    w0 = nwrites; cfg_addr_lo = 32'hFEF0_0000;
    fire(8'b0000_0001);
    repeat (8) tick();
    chk(nwrites == w0, "R2 bad window", 64'(nwrites - w0), 64'h0);
    cfg_addr_lo = 32'hFEEA_500C;
    repeat (4) tick();
    chk(nwrites == w0 + 1 && wlog[w0] == 32'h30, "R2 released", {32'h0, wlog[w0]}, 64'h30);

    // R9: 64-bit mode with nonzero upper blocks; 32-bit mode ignores upper
    w0 = nwrites; cfg_addr64 = 1'b1; cfg_addr_hi = 32'h1;
    fire(8'b0000_0100);
    repeat (6) tick();
    chk(nwrites == w0, "R9 upper nonzero", 64'(nwrites - w0), 64'h0);
    cfg_addr64 = 1'b0;
    repeat (4) tick();
    chk(nwrites == w0 + 1, "R9 32-bit mode", 64'(nwrites - w0), 64'h1);
    cfg_addr_hi = 32'h0;

    // R8 latency
    w0 = nwrites;
    tick(); cause_i = 8'b0001_0000;
    @(negedge clk); chk(!wr_valid, "R8 before", {63'h0, wr_valid}, 64'h0);
    tick(); cause_i = '0;
    @(negedge clk); chk(!wr_valid, "R8 pending edge", {63'h0, wr_valid}, 64'h0);
    tick();
    @(negedge clk); chk(wr_valid && wr_data == 32'h34, "R8 second edge", {32'h0, wr_data}, 64'h34);
    // R8 back to back: two pending, ready high, no gap
    fire(8'b1100_0000);
    tick();
    @(negedge clk); chk(wr_valid && wr_data == 32'h36, "R8 first of pair", {32'h0, wr_data}, 64'h36);
    tick();
    @(negedge clk); chk(wr_valid && wr_data == 32'h37, "R8 no gap", {32'h0, wr_data}, 64'h37);
    repeat (3) tick();

    // R7 merge
    w0 = nwrites; cfg_enable = 1'b0;
    fire(8'b0000_0100); fire(8'b0000_0100);
    cfg_enable = 1'b1;
    repeat (8) tick();
    chk(nwrites == w0 + 1, "R7 merge", 64'(nwrites - w0), 64'h1);

    // R3 clamp and k=0; R6 stall with config change
    w0 = nwrites; wr_ready = 1'b0; cfg_vec_log2 = 3'd7; cfg_data = 16'hABFF;
    fire(8'b0100_0000);
    repeat (2) tick();
    cfg_data = 16'h1111;
    repeat (4) tick();
    @(negedge clk);
    chk(wr_valid && wr_data == 32'hABE6, "R3/R6 clamp stall", {32'h0, wr_data}, 64'hABE6);
    tick(); wr_ready = 1'b1; tick();
    cfg_vec_log2 = 3'd0; cfg_data = 16'hABFF;
    fire(8'b0000_1000);
    repeat (3) tick();
    chk(nwrites == w0 + 2 && wlog[w0 + 1] == 32'hABFF, "R3 zero bits", {32'h0, wlog[w0 + 1]}, 64'hABFF);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      tick();
      cause_i      = N'($urandom & $urandom & $urandom);
      wr_ready     = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) begin
        cfg_enable   = ($urandom % 4) != 0;
        cfg_vec_log2 = 3'($urandom);
        cfg_data     = 16'($urandom);
        cfg_addr64   = 1'($urandom);
        cfg_addr_hi  = (($urandom % 4) == 0) ? 32'h10 : 32'h0;
        cfg_addr_lo  = (($urandom % 6) == 0) ? 32'hFED0_0000 : {12'hFEE, 20'($urandom)};
      end
    end
    // drain
    tick(); cause_i = '0; wr_ready = 1'b1; cfg_enable = 1'b1; cfg_addr64 = 1'b0;
    cfg_addr_lo = 32'hFEE0_1000;
    repeat (20) tick();
    @(negedge clk);
    chk(mpend == '0 && !wr_valid, "R4/R7 drain", {55'h0, wr_valid, mpend}, 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule